// File: doc/BRIEF.md
# Dual-Plane Flash Read Status Generator

This block sits on the read-data return path of a two-plane flash model. On each read it picks one of two results. When nothing is running in the addressed region, the word from the array goes out unchanged. While an embedded program or erase is active, or an erase is on hold, it returns a status word instead. Software polls this word to learn whether the operation has finished.

The status word has three defined bits and all others at 0. Bit 7 is a polling bit. Bit 6 is a toggle bit that flips on each completed read in the busy plane. Bit 2 is a second toggle bit that follows reads of the sector being erased, or of the erase that is on hold. Reads from the plane that is not busy always return array data, so one plane can be read while the other is written.

Each read is marked complete by a rising edge on a read strobe. That edge advances the toggle bits. The rules depend on two things: which plane is read compared with which plane is busy, and whether the read hits the suspended sector.

Top module: `flash_rd_status`

## Requirements
- R1: After reset both toggle bits are 0, so the first status read of a newly started operation shows 0 on bit 6.
- R2: A read from a plane whose busy input is low, and which does not hit the suspended sector, returns `array_data` unchanged (upper byte forced to 0 in byte mode).
- R3: A read from a plane that is busy programming (busy=1, op_erase=0) returns a word with bit 7 equal to the inverse of `prog_d7`, bit 6 equal to that plane's toggle bit, bit 2 equal to 1, and every other bit 0.
- R4: A read from a plane that is busy erasing (busy=1, op_erase=1) returns bit 7 = 0, bit 6 = that plane's toggle bit, bit 2 = the shared bit-2 toggle, and every other bit 0.
- R5: Each rising edge of `rd_strobe` on a read that shows a toggling bit 6 inverts that plane's bit-6 toggle exactly once, however long the strobe stays high. The toggle bits of the other plane do not change.
- R6: A rising edge on any plane's busy input clears that plane's bit-6 toggle. A rising edge on any busy input or on `susp_act` clears the bit-2 toggle.
- R7: While `susp_act` is high, a read whose plane and sector equal `susp_plane`/`susp_sector` returns bit 7 = 1, bit 6 = 1 steady, bit 2 = the bit-2 toggle (inverted by each strobe edge), and every other bit 0. This rule takes priority over the program rule.
- R8: While an erase is suspended, a read of any other sector in a plane that is not busy returns array data.
- R9: While an erase is suspended and a program runs, reads in the programming plane follow R3, and reads of the suspended sector keep toggling bit 2 under R7.
- R10: When `byte_mode` is 1, bits 15..8 of `rd_data` are 0, and bits 7..0 follow the same rules.
- R11: Once a plane's busy input returns low, reads from that plane return array data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Read completion strobe; rising edge ends a read cycle |
| rd_plane | input | PLANE_W | Plane of the current read address |
| rd_sector | input | SECT_W | Sector of the current read address |
| array_data | input | DATA_W | True data from the array at the read address |
| byte_mode | input | 1 | 1 = 8-bit read lane, upper bits forced to 0 |
| busy | input | NPLANE | Per-plane embedded operation active |
| op_erase | input | NPLANE | Per-plane operation type: 1 = erase, 0 = program |
| prog_d7 | input | 1 | Bit 7 of the data being programmed |
| susp_act | input | 1 | An erase is suspended |
| susp_plane | input | PLANE_W | Plane holding the suspended sector |
| susp_sector | input | SECT_W | Suspended sector |
| rd_data | output | DATA_W | Read result: array data or status word |

## Verification
The bench builds the block with its default values: two planes, a 5-bit sector field and a 16-bit data word. With these values each plane can be the busy one while the other is read, and the suspended sector can sit in either plane with neighbouring sectors in the same plane. Word and byte lanes both occur. Random configurations and read sequences are mixed with directed cases. The directed cases cover a strobe held high for several cycles, an operation restart clearing the toggles, and a suspended sector read while the same plane programs.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
    typedef enum logic [1:0] {
        RK_DATA  = 2'd0,
        RK_PROG  = 2'd1,
        RK_ERASE = 2'd2,
        RK_SUSP  = 2'd3
    } rkind_e;
endpackage

// File: rtl/fstat_classify.sv
module fstat_classify
    import flash_stat_pkg::*;
#(
    parameter int NPLANE  = 2,
    parameter int PLANE_W = 1,
    parameter int SECT_W  = 5
) (
    input  logic [PLANE_W-1:0] rd_plane,
    input  logic [SECT_W-1:0]  rd_sector,
    input  logic [NPLANE-1:0]  busy,
    input  logic [NPLANE-1:0]  op_erase,
    input  logic               susp_act,
    input  logic [PLANE_W-1:0] susp_plane,
    input  logic [SECT_W-1:0]  susp_sector,
    output rkind_e             kind
);
    logic hit_susp;

    always_comb begin
        hit_susp = susp_act && (rd_plane == susp_plane) && (rd_sector == susp_sector);
        if (hit_susp)
            kind = RK_SUSP;
        else if (busy[rd_plane] && !op_erase[rd_plane])
            kind = RK_PROG;
        else if (busy[rd_plane])
            kind = RK_ERASE;
        else
            kind = RK_DATA;
    end
endmodule

// File: rtl/fstat_toggles.sv
module fstat_toggles
    import flash_stat_pkg::*;
#(
    parameter int NPLANE  = 2,
    parameter int PLANE_W = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_strobe,
    input  logic [PLANE_W-1:0] rd_plane,
    input  rkind_e             kind,
    input  logic [NPLANE-1:0]  busy,
    input  logic               susp_act,
    output logic [NPLANE-1:0]  t6,
    output logic               t2
);
    typedef struct packed {
        logic [NPLANE-1:0] t6;
        logic              t2;
        logic              strb;
        logic [NPLANE-1:0] bsy;
        logic              sus;
    } tog_st_t;

    tog_st_t st_d, st_q;
    logic              rise;
    logic              tog6;
    logic [NPLANE-1:0] start_vec;
    logic              sus_rise;

    assign rise      = rd_strobe & ~st_q.strb;
    assign tog6      = (kind == RK_PROG) || (kind == RK_ERASE);
    assign start_vec = busy & ~st_q.bsy;
    assign sus_rise  = susp_act & ~st_q.sus;

    always_comb begin
        st_d      = st_q;
        st_d.strb = rd_strobe;
        st_d.bsy  = busy;
        st_d.sus  = susp_act;
        if (rise) begin
            if (tog6)
                st_d.t6[rd_plane] = ~st_q.t6[rd_plane];
            if (kind == RK_ERASE || kind == RK_SUSP)
                st_d.t2 = ~st_q.t2;
        end
        for (int p = 0; p < NPLANE; p++) begin
            if (start_vec[p])
                st_d.t6[p] = 1'b0;
        end
        if ((|start_vec) || sus_rise)
            st_d.t2 = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign t6 = st_q.t6;
    assign t2 = st_q.t2;

    AST_T6_ONE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && tog6 && !(|start_vec)) |=> ($countones(t6 ^ $past(t6)) == 1)); // R5
    AST_T6_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rise && tog6) && !(|start_vec)) |=> (t6 == $past(t6))); // R5

    for (genvar g = 0; g < NPLANE; g++) begin : g_clr
        AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
            (busy[g] && !st_q.bsy[g]) |=> !t6[g]); // R6
    end
endmodule

// File: rtl/fstat_format.sv
module fstat_format
    import flash_stat_pkg::*;
#(
    parameter int NPLANE  = 2,
    parameter int PLANE_W = 1,
    parameter int DATA_W  = 16
) (
    input  rkind_e             kind,
    input  logic [PLANE_W-1:0] rd_plane,
    input  logic [NPLANE-1:0]  t6,
    input  logic               t2,
    input  logic               prog_d7,
    input  logic [DATA_W-1:0]  array_data,
    input  logic               byte_mode,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int LANE_W = 8;

    logic [DATA_W-1:0] w;

    always_comb begin
        w = '0;
        unique case (kind)
            RK_DATA: w = array_data;
            RK_PROG: begin
                w[7] = ~prog_d7;
                w[6] = t6[rd_plane];
                w[2] = 1'b1;
            end
            RK_ERASE: begin
                w[7] = 1'b0;
                w[6] = t6[rd_plane];
                w[2] = t2;
            end
            RK_SUSP: begin
                w[7] = 1'b1;
                w[6] = 1'b1;
                w[2] = t2;
            end
            default: w = array_data;
        endcase
        if (byte_mode)
            w[DATA_W-1:LANE_W] = '0;
        rd_data = w;
    end
endmodule

// File: rtl/flash_rd_status.sv
module flash_rd_status
    import flash_stat_pkg::*;
#(
    parameter int NPLANE = 2,
    parameter int SECT_W = 5,
    parameter int DATA_W = 16,
    localparam int PLANE_W = (NPLANE > 1) ? $clog2(NPLANE) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_strobe,
    input  logic [PLANE_W-1:0] rd_plane,
    input  logic [SECT_W-1:0]  rd_sector,
    input  logic [DATA_W-1:0]  array_data,
    input  logic               byte_mode,
    input  logic [NPLANE-1:0]  busy,
    input  logic [NPLANE-1:0]  op_erase,
    input  logic               prog_d7,
    input  logic               susp_act,
    input  logic [PLANE_W-1:0] susp_plane,
    input  logic [SECT_W-1:0]  susp_sector,
    output logic [DATA_W-1:0]  rd_data
);
    rkind_e            kind;
    logic [NPLANE-1:0] t6;
    logic              t2;

    fstat_classify #(.NPLANE(NPLANE), .PLANE_W(PLANE_W), .SECT_W(SECT_W)) u_cls (
        .rd_plane(rd_plane), .rd_sector(rd_sector), .busy(busy), .op_erase(op_erase),
        .susp_act(susp_act), .susp_plane(susp_plane), .susp_sector(susp_sector),
        .kind(kind)
    );

    fstat_toggles #(.NPLANE(NPLANE), .PLANE_W(PLANE_W)) u_tog (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_plane(rd_plane),
        .kind(kind), .busy(busy), .susp_act(susp_act), .t6(t6), .t2(t2)
    );

    fstat_format #(.NPLANE(NPLANE), .PLANE_W(PLANE_W), .DATA_W(DATA_W)) u_fmt (
        .kind(kind), .rd_plane(rd_plane), .t6(t6), .t2(t2), .prog_d7(prog_d7),
        .array_data(array_data), .byte_mode(byte_mode), .rd_data(rd_data)
    );

    AST_SUSP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (susp_act && rd_plane == susp_plane && rd_sector == susp_sector)
        |-> (rd_data[7] && rd_data[6])); // R7
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        byte_mode |-> (rd_data[DATA_W-1:8] == '0)); // R10
    AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy == '0 && !susp_act && !byte_mode) |-> (rd_data == array_data)); // R2
endmodule

// File: tb/flash_rd_status_test.sv
module flash_rd_status_test;
    localparam int NPLANE = 2;
    localparam int SECT_W = 5;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_strobe = 1'b0;
    logic [0:0]        rd_plane = '0;
    logic [SECT_W-1:0] rd_sector = '0;
    logic [DATA_W-1:0] array_data = '0;
    logic              byte_mode = 1'b0;
    logic [NPLANE-1:0] busy = '0;
    logic [NPLANE-1:0] op_erase = '0;
    logic              prog_d7 = 1'b0;
    logic              susp_act = 1'b0;
    logic [0:0]        susp_plane = '0;
    logic [SECT_W-1:0] susp_sector = '0;
    logic [DATA_W-1:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [NPLANE-1:0] m6 = '0;
    logic              m2 = 1'b0;

    always #4 clk = ~clk;

    flash_rd_status uut (
        .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_plane(rd_plane),
        .rd_sector(rd_sector), .array_data(array_data), .byte_mode(byte_mode),
        .busy(busy), .op_erase(op_erase), .prog_d7(prog_d7), .susp_act(susp_act),
        .susp_plane(susp_plane), .susp_sector(susp_sector), .rd_data(rd_data)
    );

    // 0 data, 1 program, 2 erase, 3 suspended sector
    function automatic int kind_of(input logic pl, input logic [SECT_W-1:0] sc);
        if (susp_act && pl == susp_plane[0] && sc == susp_sector) return 3;
        if (busy[pl] && !op_erase[pl]) return 1;
        if (busy[pl]) return 2;
        return 0;
    endfunction

    function automatic logic [DATA_W-1:0] exp_word(input logic pl, input logic [SECT_W-1:0] sc,
                                                   input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] w;
        w = '0;
        case (kind_of(pl, sc))
            0: w = d;
            1: begin w[7] = ~prog_d7; w[6] = m6[pl]; w[2] = 1'b1; end
            2: begin w[7] = 1'b0; w[6] = m6[pl]; w[2] = m2; end
            default: begin w[7] = 1'b1; w[6] = 1'b1; w[2] = m2; end
        endcase
        if (byte_mode) w[DATA_W-1:8] = '0;
        return w;
    endfunction

    task automatic check(input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [NPLANE-1:0] b, input logic [NPLANE-1:0] er, input logic d7,
                           input logic sa, input logic sp, input logic [SECT_W-1:0] ss);
        logic start;
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < NPLANE; p++) begin
            if (b[p] && !busy[p]) begin m6[p] = 1'b0; start = 1'b1; end
        end
        if (sa && !susp_act) start = 1'b1;
        if (start) m2 = 1'b0;
        busy = b; op_erase = er; prog_d7 = d7;
        susp_act = sa; susp_plane = sp; susp_sector = ss;
        @(negedge clk);
    endtask

    task automatic do_read(input logic pl, input logic [SECT_W-1:0] sc, input logic [DATA_W-1:0] d,
                           input int hold, input string tag);
        int k;
        @(negedge clk);
        rd_plane = pl; rd_sector = sc; array_data = d;
        #1;
        check(rd_data, exp_word(pl, sc, d), tag);
        k = kind_of(pl, sc);
        rd_strobe = 1'b1;
        repeat (hold) @(negedge clk);
        rd_strobe = 1'b0;
        if (k == 1 || k == 2) m6[pl] = ~m6[pl];
        if (k == 2 || k == 3) m2 = ~m2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0c1e));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 R2: idle after reset
        do_read(1'b0, 5'd1, 16'hA5C3, 1, "R1 idle read");
        do_read(1'b1, 5'd9, 16'h1234, 1, "R2 idle read");
        // R3 R5 R6: program in plane 0
        set_cfg(2'b01, 2'b00, 1'b1, 1'b0, 1'b0, 5'd0);
        do_read(1'b0, 5'd2, 16'hFFFF, 1, "R1 R3 first status");
        do_read(1'b0, 5'd2, 16'hFFFF, 1, "R5 R3 second status");
        do_read(1'b1, 5'd7, 16'h7E81, 1, "R2 other plane");
        do_read(1'b0, 5'd2, 16'hFFFF, 4, "R5 before long strobe");
        do_read(1'b0, 5'd2, 16'hFFFF, 1, "R5 after long strobe");
        // R6: restart clears toggles; R11 completion
        set_cfg(2'b00, 2'b00, 1'b1, 1'b0, 1'b0, 5'd0);
        do_read(1'b0, 5'd2, 16'h0F0F, 1, "R11 done returns data");
        set_cfg(2'b01, 2'b00, 1'b0, 1'b0, 1'b0, 5'd0);
        do_read(1'b0, 5'd2, 16'h0F0F, 1, "R6 restart clears bit6");
        // R4: erase in plane 1
        set_cfg(2'b10, 2'b10, 1'b0, 1'b0, 1'b0, 5'd0);
        do_read(1'b1, 5'd4, 16'hBEEF, 1, "R4 erase status a");
        do_read(1'b1, 5'd4, 16'hBEEF, 1, "R4 erase status b");
        do_read(1'b1, 5'd4, 16'hBEEF, 1, "R4 erase status c");
        // R7 R8: suspended sector 3 in plane 1
        set_cfg(2'b00, 2'b00, 1'b0, 1'b1, 1'b1, 5'd3);
        do_read(1'b1, 5'd3, 16'h1111, 1, "R7 susp sector a");
        do_read(1'b1, 5'd3, 16'h1111, 1, "R7 susp sector b");
        do_read(1'b1, 5'd4, 16'h2222, 1, "R8 other sector");
        do_read(1'b0, 5'd3, 16'h3333, 1, "R8 other plane");
        // R9: program in the suspended plane
        set_cfg(2'b10, 2'b00, 1'b0, 1'b1, 1'b1, 5'd3);
        do_read(1'b1, 5'd4, 16'h4444, 1, "R9 program status");
        do_read(1'b1, 5'd3, 16'h5555, 1, "R9 susp sector bit2");
        do_read(1'b1, 5'd3, 16'h5555, 1, "R9 susp sector bit2 again");
        do_read(1'b1, 5'd4, 16'h4444, 1, "R9 program status again");
        // R10: byte lane
        byte_mode = 1'b1;
        do_read(1'b1, 5'd4, 16'hFFFF, 1, "R10 byte status");
        do_read(1'b0, 5'd4, 16'hABCD, 1, "R10 byte data");
        byte_mode = 1'b0;
        // random mix
        for (int i = 0; i < 400; i++) begin
            if (i % 8 == 0) begin
                int c;
                logic pl;
                c = $urandom % 5;
                pl = 1'($urandom);
                case (c)
                    0: set_cfg(2'b00, 2'b00, 1'($urandom), 1'b0, 1'b0, 5'd0);
                    1: set_cfg(2'b01 << pl, 2'b00, 1'($urandom), 1'b0, 1'b0, 5'd0);
                    2: set_cfg(2'b01 << pl, 2'b01 << pl, 1'b0, 1'b0, 1'b0, 5'd0);
                    3: set_cfg(2'b00, 2'b00, 1'b0, 1'b1, pl, 5'($urandom % 4));
                    default: set_cfg(2'b01 << 1'($urandom), 2'b00, 1'($urandom), 1'b1, pl,
                                     5'($urandom % 4));
                endcase
                byte_mode = 1'($urandom);
            end
            do_read(1'($urandom), 5'($urandom % 4), 16'($urandom), 1 + ($urandom % 3),
                    "R2 R3 R4 R5 R7 R9 random");
        end
        finish_run();
    end
endmodule